// File: doc/BRIEF.md
# Square-Tone Channel Generator

This block produces one square-wave voice of a programmable sound generator. A divide-by-16 prescaler inside the block paces a 10-bit down-counter. Each time the counter runs out, it reloads from the period register and the one-bit phase output flips. The tone frequency is therefore the master clock divided by 32 times the period.

The prescaler's wrap pulse is brought out as a tick so that sibling channels can run on the same divided time base. The stored period is also brought out so that a noise channel can borrow it. A period write never disturbs the phase or the count in progress: the new value is picked up at the next reload.

A parameter selects what a period of zero means. With `ZERO_IS_MAX = 1` the counter decrements before it tests for zero, so zero acts as 1024 and gives the lowest pitch. With `ZERO_IS_MAX = 0` zero acts exactly like one and gives the highest pitch.

Top module: `tone_channel`

## Requirements
- R1: While `rst` is high at a clock edge, the following edge leaves `phase` = 0, `tick` = 0 and `period_q` = 0. After `rst` falls, `tick` is first high in the 15th clock cycle.
- R2: `tick` is high for exactly one cycle in every 16 clock cycles.
- R3: `period_q` takes the value of `period_in` on the edge where `period_we` is 1, and holds its value on every other edge.
- R4: With a stored period N in 1..1023, `phase` stays at each level for 16*N clock cycles.
- R5: With `ZERO_IS_MAX = 0`, a stored period of 0 gives levels 16 clock cycles long, the same as a period of 1.
- R6: With `ZERO_IS_MAX = 1`, a stored period of 0 gives levels 16384 clock cycles long.
- R7: A period write leaves `phase` and the count in progress unchanged. The new period first applies to the level that starts at the next toggle.
- R8: After reset the counter starts at zero. With `ZERO_IS_MAX = 0` the first toggle of `phase` comes 16 cycles after `rst` falls; with `ZERO_IS_MAX = 1` it comes after 16384 cycles.
- R9: `phase` changes only on an edge where `tick` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| period_in | input | 10 | Period value to store |
| period_we | input | 1 | Write strobe for `period_in` |
| phase | output | 1 | Square-wave output level |
| tick | output | 1 | One-cycle pulse each time the prescaler wraps |
| period_q | output | 10 | Stored period, for other channels to use |

## Verification
The bench builds two copies of the block: `uut` with `ZERO_IS_MAX = 0` and `uut_lo` with `ZERO_IS_MAX = 1`. Between them both meanings of a zero period can be observed at the ports. These are the 16-cycle fastest tone and the 16384-cycle slowest tone, the latter also reached as the first toggle after reset. The zero-meaning variant copy also covers periods from 1 to 1023 and a write made part-way through a level.

// File: rtl/tone_channel.sv
module tone_channel #(
  parameter int PW          = 10,
  parameter int PRESCALE    = 16,
  parameter bit ZERO_IS_MAX = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] period_in,
  input  logic          period_we,
  output logic          phase,
  output logic          tick,
  output logic [PW-1:0] period_q
);
  localparam int SW = $clog2(PRESCALE);
  localparam logic [SW-1:0] PRE_LAST = SW'(PRESCALE - 1);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [SW-1:0] pre;
  logic [PW-1:0] cnt;
  logic          expire;

  assign tick = (pre == PRE_LAST);

  generate
    if (ZERO_IS_MAX) begin : g_dec_first
      assign expire = (cnt == ONE);
    end else begin : g_zero_fast
      assign expire = (cnt <= ONE);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pre      <= '0;
      cnt      <= '0;
      phase    <= 1'b0;
      period_q <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (period_we) period_q <= period_in;
      if (tick) begin
        if (expire) begin
          cnt   <= period_q;
          phase <= ~phase;
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end
endmodule

module tone_channel_chk #(
  parameter int PW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic [PW-1:0] period_in,
  input logic          period_we,
  input logic          phase,
  input logic          tick,
  input logic [PW-1:0] period_q
);
  logic [4:0] gap;
  logic       seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (tick) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap <= gap + 5'd1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (phase == 1'b0 && tick == 1'b0 && period_q == '0));

  // R2
  tick_width_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && seen) |-> (gap == 5'd15));

  // R3
  period_load_chk: assert property (@(posedge clk) disable iff (rst)
    (period_we && !$past(rst)) |=> (period_q == $past(period_in)));

  // R3
  period_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !period_we |=> $stable(period_q));

  // R9
  phase_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(phase));

  // R7
  write_no_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (period_we && !tick) |=> $stable(phase));
endmodule

bind tone_channel tone_channel_chk #(.PW(PW)) u_chk (.*);

// File: tb/tone_channel_test.sv
module tone_channel_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] per_b = '0, per_a = '0;
  logic       we_b = 1'b0, we_a = 1'b0;
  logic       ph_b, tk_b, ph_a, tk_a;
  logic [9:0] pq_b, pq_a;
  int total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;

  tone_channel #(.ZERO_IS_MAX(1'b0)) uut (.clk(clk), .rst(rst), .period_in(per_b),
    .period_we(we_b), .phase(ph_b), .tick(tk_b), .period_q(pq_b));
  tone_channel #(.ZERO_IS_MAX(1'b1)) uut_lo (.clk(clk), .rst(rst), .period_in(per_a),
    .period_we(we_a), .phase(ph_a), .tick(tk_a), .period_q(pq_a));

  localparam int NV = 7;
  localparam int VEC[NV][2] = '{'{1,16}, '{2,32}, '{5,80}, '{0,16},
                                 '{17,272}, '{1023,16368}, '{3,48}};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_to_toggle(input bit sel_a, output int n);
    logic p0;
    p0 = sel_a ? ph_a : ph_b;
    n = 0;
    while (((sel_a ? ph_a : ph_b) == p0) && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wr(input bit sel_a, input logic [9:0] v);
    if (sel_a) begin per_a = v; we_a = 1'b1; end
    else begin per_b = v; we_b = 1'b1; end
    @(negedge clk);
    we_a = 1'b0; we_b = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, first_b, first_a, first_tk, ticks;
    logic pb, pa, ph0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 phase", ph_b, 0); chk("R1 tick", tk_b, 0); chk("R1 period_q", pq_a, 0);
    rst = 1'b0;
    first_b = 0; first_a = 0; first_tk = 0; ticks = 0;
    pb = ph_b; pa = ph_a;
    for (int i = 1; i <= 16400; i++) begin
      @(negedge clk);
      if (tk_b) begin ticks++; if (first_tk == 0) first_tk = i; end
      if (ph_b != pb && first_b == 0) first_b = i;
      if (ph_a != pa && first_a == 0) first_a = i;
    end
    chk("R1 first tick", first_tk, 15);
    chk("R2 tick count", ticks, 1025);
    chk("R8 first toggle zero-fast", first_b, 16);
    chk("R8 first toggle zero-max", first_a, 16384);

    for (int k = 0; k < NV; k++) begin
      wr(1'b0, 10'(VEC[k][0]));
      chk("R3 period_q", pq_b, VEC[k][0]);
      run_to_toggle(1'b0, n);
      run_to_toggle(1'b0, n);
      chk((VEC[k][0] == 0) ? "R5 zero as one" : "R4 half period", n, VEC[k][1]);
    end

    // R7: write mid-level at period 3, level length stays 48, next is 640
    ph0 = ph_b;
    for (int i = 1; i <= 47; i++) begin
      if (i == 10) begin per_b = 10'd40; we_b = 1'b1; end
      @(negedge clk);
      we_b = 1'b0;
      if (i == 12) chk("R7 phase held after write", ph_b, ph0);
    end
    chk("R7 old level still running", ph_b, ph0);
    @(negedge clk);
    chk("R7 toggle at old length", ph_b, !ph0);
    run_to_toggle(1'b0, n);
    chk("R7 new period at next reload", n, 640);

    wr(1'b1, 10'd3);
    chk("R3 period_q zero-max", pq_a, 3);
    run_to_toggle(1'b1, n);
    run_to_toggle(1'b1, n);
    chk("R4 zero-max period 3", n, 48);
    wr(1'b1, 10'd0);
    run_to_toggle(1'b1, n);
    run_to_toggle(1'b1, n);
    chk("R6 zero as 1024", n, 16384);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule